// File: doc/BRIEF.md
# I/O Interrupt Acknowledge Responder

This block answers the processor's interrupt-acknowledge request when several I/O sources may be waiting at once. Each source raises a one-cycle event. The block latches that event as a pending flag and stores the status word the source presents with it. Every source also has a rank held in a register, and the rank is set through a small configuration port. The ranks fix the service order, and that order has nothing to do with which port a source is wired to.

An acknowledge carries a cluster/unit selection code and a destination register field. Only a selection code of zero requests the standard acknowledge. For that request the block picks the pending source with the best rank and clears its pending flag. One cycle later it returns a condition code. If the destination field is not zero, it also returns a register-file write enable, the register index and a response word. The response word identifies the source, so the requester never names the source itself.

Top module: `iack_responder`

## Requirements
- R1: After reset, `rsp_valid` and `rsp_wr_en` are 0, no source is pending, and source i has rank i.
- R2: `rsp_valid` is 1 in exactly the cycle after a cycle in which `ack_req` was 1. The response fields sit on the outputs in that same cycle.
- R3: A standard acknowledge with at least one source pending returns condition code 4'b0100. The response word holds the source's stored status in bits [31:16], zeros in bits [15:3] and the source's port index in bits [2:0].
- R4: Among pending sources, the one with the numerically smallest rank wins. Rank 0 is the best.
- R5: When two pending sources have equal ranks, the lower port index wins.
- R6: Writing `cfg_rank` to source `cfg_idx` with `cfg_we` changes the order used by later acknowledges.
- R7: The granted source's pending flag clears at the edge that registers the response. A back-to-back acknowledge in the next cycle therefore selects the next source.
- R8: A register field of 0 still returns the condition code and still clears the granted source, but `rsp_wr_en` stays 0. A nonzero field asserts `rsp_wr_en`, with `rsp_wr_idx` equal to the field.
- R9: A standard acknowledge with nothing pending returns condition code 4'b0000, and `rsp_wr_en` stays 0 for any register field.
- R10: An acknowledge with a nonzero selection code returns condition code 4'b0010. It does not write a register and does not clear any pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_raise | input | 8 | One-cycle interrupt event per source |
| src_stat | input | 128 | 16-bit status per source, captured on raise (source i at [16i+15:16i]) |
| cfg_we | input | 1 | Rank write strobe |
| cfg_idx | input | 3 | Source whose rank is written |
| cfg_rank | input | 3 | New rank, 0 is best |
| ack_req | input | 1 | Acknowledge request strobe |
| ack_cu | input | 6 | Cluster/unit selection code, zero for standard acknowledge |
| ack_rf | input | 4 | Destination register field |
| rsp_valid | output | 1 | Response present |
| rsp_cc | output | 4 | Condition code |
| rsp_wr_en | output | 1 | Register-file write enable |
| rsp_wr_idx | output | 4 | Register-file write index |
| rsp_wr_data | output | 32 | Response word |

## Verification
The bound checker enforces several rules on every cycle. It ties each response to the acknowledge one cycle earlier. It checks that a write only accompanies a grant condition code with a nonzero register index, and that both the nothing-pending code and the reserved-selection code suppress the write. Priority order, tie-breaking, rank reprogramming, the draining of sources by back-to-back acknowledges and the survival of a pending flag across a rejected request depend on history. Only the bench's directed scenarios, run against a reference model of the pending set, can show those.

// File: rtl/iack_pkg.sv
package iack_pkg;
    localparam int N_SRC  = 8;
    localparam int RANK_W = 3;
    localparam int STAT_W = 16;
    localparam int DATA_W = 32;
    localparam int RF_W   = 4;
    localparam int CU_W   = 6;

    typedef enum logic [3:0] {
        CC_NONE   = 4'b0000,
        CC_BADSEL = 4'b0010,
        CC_GRANT  = 4'b0100
    } cc_e;
endpackage

// File: rtl/iack_src_bank.sv
module iack_src_bank #(
    parameter int N_SRC  = iack_pkg::N_SRC,
    parameter int RANK_W = iack_pkg::RANK_W,
    parameter int STAT_W = iack_pkg::STAT_W,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_SRC-1:0]        raise,
    input  logic [N_SRC*STAT_W-1:0] stat_in,
    input  logic                    cfg_we,
    input  logic [IDX_W-1:0]        cfg_idx,
    input  logic [RANK_W-1:0]       cfg_rank,
    input  logic                    clr_en,
    input  logic [IDX_W-1:0]        clr_idx,
    output logic [N_SRC-1:0]        pend,
    output logic [N_SRC*STAT_W-1:0] stat_out,
    output logic [N_SRC*RANK_W-1:0] rank_out
);
    typedef struct packed {
        logic [N_SRC-1:0]             pend;
        logic [N_SRC-1:0][STAT_W-1:0] stat;
        logic [N_SRC-1:0][RANK_W-1:0] rank;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N_SRC; i++) begin
            if (clr_en && clr_idx == IDX_W'(i))
                st_d.pend[i] = 1'b0;
            if (raise[i]) begin
                st_d.pend[i] = 1'b1;
                st_d.stat[i] = stat_in[i*STAT_W +: STAT_W];
            end
            if (cfg_we && cfg_idx == IDX_W'(i))
                st_d.rank[i] = cfg_rank;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pend <= '0;
            st_q.stat <= '0;
            for (int i = 0; i < N_SRC; i++)
                st_q.rank[i] <= RANK_W'(i);
        end else begin
            st_q <= st_d;
        end
    end

    assign pend     = st_q.pend;
    assign stat_out = st_q.stat;
    assign rank_out = st_q.rank;
endmodule

// File: rtl/iack_prio_pick.sv
module iack_prio_pick #(
    parameter int N_SRC  = iack_pkg::N_SRC,
    parameter int RANK_W = iack_pkg::RANK_W,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0]        pend,
    input  logic [N_SRC*RANK_W-1:0] rank,
    output logic                    hit,
    output logic [IDX_W-1:0]        idx
);
    logic [RANK_W-1:0] best;

    // ascending scan with strict compare: equal ranks keep the lower port
    always_comb begin
        hit  = 1'b0;
        idx  = '0;
        best = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (pend[i] && (!hit || rank[i*RANK_W +: RANK_W] < best)) begin
                hit  = 1'b1;
                idx  = IDX_W'(i);
                best = rank[i*RANK_W +: RANK_W];
            end
        end
    end
endmodule

// File: rtl/iack_responder.sv
module iack_responder #(
    parameter int N_SRC  = iack_pkg::N_SRC,
    parameter int RANK_W = iack_pkg::RANK_W,
    parameter int STAT_W = iack_pkg::STAT_W,
    parameter int DATA_W = iack_pkg::DATA_W,
    parameter int RF_W   = iack_pkg::RF_W,
    parameter int CU_W   = iack_pkg::CU_W,
    localparam int IDX_W = $clog2(N_SRC),
    localparam int PAD_W = DATA_W - STAT_W - IDX_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_SRC-1:0]        src_raise,
    input  logic [N_SRC*STAT_W-1:0] src_stat,
    input  logic                    cfg_we,
    input  logic [IDX_W-1:0]        cfg_idx,
    input  logic [RANK_W-1:0]       cfg_rank,
    input  logic                    ack_req,
    input  logic [CU_W-1:0]         ack_cu,
    input  logic [RF_W-1:0]         ack_rf,
    output logic                    rsp_valid,
    output logic [3:0]              rsp_cc,
    output logic                    rsp_wr_en,
    output logic [RF_W-1:0]         rsp_wr_idx,
    output logic [DATA_W-1:0]       rsp_wr_data
);
    import iack_pkg::*;

    typedef struct packed {
        logic              valid;
        logic [3:0]        cc;
        logic              wr_en;
        logic [RF_W-1:0]   wr_idx;
        logic [DATA_W-1:0] wr_data;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic [N_SRC-1:0]        pend;
    logic [N_SRC*STAT_W-1:0] stat_all;
    logic [N_SRC*RANK_W-1:0] rank_all;
    logic                    hit;
    logic [IDX_W-1:0]        win;
    logic                    std_ack;
    logic                    grant;

    assign std_ack = ack_req && (ack_cu == '0);
    assign grant   = std_ack && hit;

    iack_src_bank #(.N_SRC(N_SRC), .RANK_W(RANK_W), .STAT_W(STAT_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .raise    (src_raise),
        .stat_in  (src_stat),
        .cfg_we   (cfg_we),
        .cfg_idx  (cfg_idx),
        .cfg_rank (cfg_rank),
        .clr_en   (grant),
        .clr_idx  (win),
        .pend     (pend),
        .stat_out (stat_all),
        .rank_out (rank_all)
    );

    iack_prio_pick #(.N_SRC(N_SRC), .RANK_W(RANK_W)) u_pick (
        .pend (pend),
        .rank (rank_all),
        .hit  (hit),
        .idx  (win)
    );

    always_comb begin
        rsp_d         = '0;
        rsp_d.valid   = ack_req;
        rsp_d.wr_idx  = ack_rf;
        if (ack_req) begin
            if (!std_ack) begin
                rsp_d.cc = CC_BADSEL;
            end else if (!hit) begin
                rsp_d.cc = CC_NONE;
            end else begin
                rsp_d.cc      = CC_GRANT;
                rsp_d.wr_en   = (ack_rf != '0);
                rsp_d.wr_data = {stat_all[win*STAT_W +: STAT_W], {PAD_W{1'b0}}, win};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid   = rsp_q.valid;
    assign rsp_cc      = rsp_q.cc;
    assign rsp_wr_en   = rsp_q.wr_en;
    assign rsp_wr_idx  = rsp_q.wr_idx;
    assign rsp_wr_data = rsp_q.wr_data;
endmodule

// File: rtl/iack_responder_chk.sv
module iack_responder_chk #(
    parameter int RF_W = iack_pkg::RF_W,
    parameter int CU_W = iack_pkg::CU_W
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ack_req,
    input logic [CU_W-1:0] ack_cu,
    input logic [RF_W-1:0] ack_rf,
    input logic            rsp_valid,
    input logic [3:0]      rsp_cc,
    input logic            rsp_wr_en,
    input logic [RF_W-1:0] rsp_wr_idx
);
    import iack_pkg::*;

    // R2
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == $past(ack_req));

    // R8
    write_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_wr_en |-> (rsp_valid && rsp_cc == CC_GRANT && rsp_wr_idx != '0));

    // R8
    rf_passed_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |=> (rsp_wr_idx == $past(ack_rf)));

    // R9
    none_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_cc == CC_NONE) |-> !rsp_wr_en);

    // R10
    bad_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && ack_cu != '0) |=> (rsp_cc == CC_BADSEL && !rsp_wr_en));
endmodule

bind iack_responder iack_responder_chk #(.RF_W(RF_W), .CU_W(CU_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ack_req    (ack_req),
    .ack_cu     (ack_cu),
    .ack_rf     (ack_rf),
    .rsp_valid  (rsp_valid),
    .rsp_cc     (rsp_cc),
    .rsp_wr_en  (rsp_wr_en),
    .rsp_wr_idx (rsp_wr_idx)
);

// File: tb/iack_responder_test.sv
module iack_responder_test;
    localparam int N = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src_raise = '0;
    logic [N*16-1:0] src_stat = '0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_idx = '0;
    logic [2:0]    cfg_rank = '0;
    logic          ack_req = 1'b0;
    logic [5:0]    ack_cu = '0;
    logic [3:0]    ack_rf = '0;
    logic          rsp_valid;
    logic [3:0]    rsp_cc;
    logic          rsp_wr_en;
    logic [3:0]    rsp_wr_idx;
    logic [31:0]   rsp_wr_data;

    int checks = 0;
    int fails  = 0;

    logic        m_pend [N];
    logic [15:0] m_stat [N];
    logic [2:0]  m_rank [N];

    always #2.5 clk = ~clk;

    iack_responder uut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic raise(input int i, input logic [15:0] s);
        @(negedge clk);
        src_raise[i] = 1'b1;
        src_stat[i*16 +: 16] = s;
        @(negedge clk);
        src_raise = '0;
        m_pend[i] = 1'b1;
        m_stat[i] = s;
    endtask

    task automatic set_rank(input int i, input logic [2:0] r);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'(i); cfg_rank = r;
        @(negedge clk);
        cfg_we = 1'b0;
        m_rank[i] = r;
    endtask

    function automatic int model_pick();
        int best = -1;
        for (int i = 0; i < N; i++)
            if (m_pend[i] && (best < 0 || m_rank[i] < m_rank[best])) best = i;
        return best;
    endfunction

    // one acknowledge; caller's negedge alignment gives back-to-back issue
    task automatic ack(input string req, input logic [5:0] cu, input logic [3:0] rf,
                       input int exp_src);
        int w;
        ack_req = 1'b1; ack_cu = cu; ack_rf = rf;
        w = (cu == 0) ? model_pick() : -1;
        @(negedge clk);
        ack_req = 1'b0;
        chk({req, " valid"}, 32'(rsp_valid), 32'd1);
        if (cu != 0) begin
            chk({req, " R10 cc"}, 32'(rsp_cc), 32'b0010);
            chk({req, " R10 wr"}, 32'(rsp_wr_en), 32'd0);
        end else if (w < 0) begin
            chk({req, " R9 cc"}, 32'(rsp_cc), 32'b0000);
            chk({req, " R9 wr"}, 32'(rsp_wr_en), 32'd0);
        end else begin
            chk({req, " R3 cc"}, 32'(rsp_cc), 32'b0100);
            chk({req, " src"}, 32'(rsp_wr_data[2:0]), 32'(exp_src));
            chk({req, " model"}, 32'(exp_src), 32'(w));
            chk({req, " R3 word"}, rsp_wr_data, {m_stat[w], 13'b0, 3'(w)});
            chk({req, " R8 wr"}, 32'(rsp_wr_en), 32'(rf != 0));
            if (rf != 0) chk({req, " R8 idx"}, 32'(rsp_wr_idx), 32'(rf));
            m_pend[w] = 1'b0;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 valid", 32'(rsp_valid), 32'd0);
        chk("R1 wr", 32'(rsp_wr_en), 32'd0);
        @(negedge clk);
        ack("R1 empty", 6'd0, 4'd3, -1);
    endtask

    task automatic t_single();
        raise(5, 16'hBEEF);
        @(negedge clk);
        ack("R2 single", 6'd0, 4'd7, 5);
        ack("R7 drained", 6'd0, 4'd7, -1);
    endtask

    task automatic t_default_order();
        raise(6, 16'h6666); raise(2, 16'h2222); raise(4, 16'h4444);
        @(negedge clk);
        ack("R4 first", 6'd0, 4'd1, 2);
        ack("R7 second", 6'd0, 4'd1, 4);
        ack("R7 third", 6'd0, 4'd1, 6);
        ack("R9 none", 6'd0, 4'd9, -1);
    endtask

    task automatic t_reprogram();
        set_rank(6, 3'd0);
        set_rank(0, 3'd7);
        raise(0, 16'h0A0A); raise(6, 16'h6060); raise(3, 16'h3030);
        @(negedge clk);
        ack("R6 rank0", 6'd0, 4'd2, 6);
        ack("R6 mid", 6'd0, 4'd2, 3);
        ack("R6 last", 6'd0, 4'd2, 0);
    endtask

    task automatic t_tie();
        set_rank(1, 3'd5); set_rank(7, 3'd5); set_rank(4, 3'd5);
        raise(7, 16'h7777); raise(4, 16'h4040); raise(1, 16'h1111);
        @(negedge clk);
        ack("R5 tie a", 6'd0, 4'd4, 1);
        ack("R5 tie b", 6'd0, 4'd4, 4);
        ack("R5 tie c", 6'd0, 4'd4, 7);
    endtask

    task automatic t_rf_zero();
        raise(2, 16'hC0DE); raise(5, 16'h5A5A);
        @(negedge clk);
        ack("R8 rf0", 6'd0, 4'd0, 2);
        ack("R8 next", 6'd0, 4'd6, 5);
    endtask

    task automatic t_badsel();
        raise(3, 16'hFACE);
        @(negedge clk);
        ack("R10 bad", 6'd1, 4'd5, -1);
        ack("R10 bad hi", 6'd32, 4'd5, -1);
        ack("R10 kept", 6'd0, 4'd5, 3);
    endtask

    initial begin
        #1ms;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_pend[i] = 1'b0; m_stat[i] = '0; m_rank[i] = 3'(i);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_default_order();
        t_reprogram();
        t_tie();
        t_rf_zero();
        t_badsel();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule